// File: doc/BRIEF.md
# Self-Timed Byte-Wide EEPROM Write Sequencer

This block is the digital control core of a byte-wide parallel EEPROM. Its host side looks like an asynchronous static RAM: an active-low chip enable, output enable and write enable, an address bus and separate input and output data buses (a pad ring combines the two data buses into one bidirectional bus). A fast system clock samples every pin. A write is captured from those pins and then runs as a self-timed sequence: the target byte is first erased to all ones, then programmed with the captured value. For the whole sequence an open-drain ready/busy line is pulled low.

A host that does not watch the ready/busy line can poll instead. While the sequence runs, reading back the address just written returns bit 7 inverted. Two digital flags stand in for the high-voltage qualifiers. With the output-enable flag set, a write cycle becomes a timed chip clear that sets the whole main array to 0xFF. With the address flag set, the top 32 addresses select a separate identification row instead of the main array. A digital supply-good input stands in for the undervoltage detector. The main array depth is `2**ADDR_W`. The full-size device uses `ADDR_W = 13`, and the default is smaller to keep elaboration light.

Top module: `eeprom_write_seq`

## Requirements
- R1: The write address is taken from the address pins at the moment the second of `ceN`/`weN` goes low. Later address changes during the same cycle are ignored.
- R2: The write data is taken from `dataIn` at the moment the first of `ceN`/`weN` returns high. Data changes after that point are ignored.
- R3: `rdyBusyN` is pulled low no more than 4 clocks after the capturing rising edge of a write. It stays low for exactly `WRITE_CYCLES` clocks and is then released (it reads high through a pull-up).
- R4: Each byte write erases the location to 0xFF and then programs it. After the write completes, the location reads back exactly the new value, whatever it held before.
- R5: While a byte write is busy, a read of the address being written returns the complement of the written bit 7 on `dataOut[7]`. Once the write is complete, the true byte is returned.
- R6: A write cycle that begins while busy is ignored entirely. It changes neither the captured address nor the captured data, and it stores nothing.
- R7: No write starts when `oeN` is low when the cycle is captured, or when `supplyOk` is low. `rdyBusyN` stays released and memory is unchanged.
- R8: `dataOe` is high only when `ceN` and `oeN` are low and `weN` is high. With `ceN` high the outputs are released regardless of `oeN`.
- R9: A write cycle with `hvOe` set starts a chip clear. It is busy for `CLEAR_CYCLES` clocks, sets every main-array byte to 0xFF, and leaves the identification row unchanged.
- R10: With `hvA9` set, addresses whose upper `ADDR_W-5` bits are all ones access a separate 32-byte row indexed by `addr[4:0]`. The row is read and written the same way as the main array, and the main array at the same addresses is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| hvOe | input | 1 | High-voltage qualifier on output enable (chip clear) |
| hvA9 | input | 1 | High-voltage qualifier selecting the identification row |
| supplyOk | input | 1 | Supply-good flag; low inhibits writes |
| addr | input | ADDR_W | Byte address |
| dataIn | input | 8 | Write data from the pad |
| dataOut | output | 8 | Read data to the pad |
| dataOe | output | 1 | Pad output enable for `dataOut` |
| rdyBusyN | output | 1 | Open-drain ready/busy: driven 0 when busy, high impedance when ready |

## Verification
The assertions assume the host pins behave like a slow asynchronous bus. Each control transition is held for at least two sampling clocks. Address and data are steady across the edge that captures them, so the synchronised copies never show a half-changed cycle. The bench drives every pin on the falling clock edge, changes only one control pin at a time, and waits three clocks between changes. This keeps every edge event distinct and never lets a start and an end fall in the same sampled cycle.

// File: rtl/eews_pkg.sv
package eews_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ERASE,
    ST_PROG,
    ST_CLEAR
  } seqState_t;

  // Strobes and levels handed from the sequencer to the datapath.
  typedef struct packed {
    logic latchAddr;    // take address / plane at cycle start
    logic latchData;    // take data at cycle end (committed byte write)
    logic eraseByte;    // write erased value to latched location
    logic programByte;  // write latched data to latched location
    logic sweepStart;   // restart chip-clear address sweep
    logic sweepStep;    // erase one main-array byte and advance
    logic byteBusy;     // byte write sequence in progress (polling)
  } seqStrobe_t;

  localparam int unsigned IDROW_BYTES = 32;
  localparam int unsigned IDROW_AW    = 5;
  localparam logic [7:0]  ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/eews_pin_sync.sv
module eews_pin_sync #(
  parameter int ADDR_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic              hvOe,
  input  logic              hvA9,
  input  logic              supplyOk,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output logic              sCeN,
  output logic              sWeN,
  output logic              sOeN,
  output logic              sHvOe,
  output logic              sHvA9,
  output logic              sSupplyOk,
  output logic [ADDR_W-1:0] sAddr,
  output logic [7:0]        sData,
  output logic              startEv,
  output logic              endEv
);

  localparam int CTL_W = 6;
  localparam int BUS_W = CTL_W + ADDR_W + 8;
  localparam logic [BUS_W-1:0] RST_BUS = {3'b111, 3'b000, {(ADDR_W + 8){1'b0}}};

  logic [BUS_W-1:0] rawBus;
  logic [BUS_W-1:0] stage [SYNC_STAGES];
  logic             wrAct;
  logic             actPrev;

  assign rawBus = {ceN, weN, oeN, hvOe, hvA9, supplyOk, addr, dataIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) stage[i] <= RST_BUS;
      actPrev <= 1'b0;
    end else begin
      stage[0] <= rawBus;
      for (int i = 1; i < SYNC_STAGES; i++) stage[i] <= stage[i-1];
      actPrev <= wrAct;
    end
  end

  assign {sCeN, sWeN, sOeN, sHvOe, sHvA9, sSupplyOk, sAddr, sData} = stage[SYNC_STAGES-1];

  // Cycle is active while both enables are low: start = later fall, end = earlier rise.
  assign wrAct   = !sCeN && !sWeN;
  assign startEv = wrAct && !actPrev;
  assign endEv   = !wrAct && actPrev;

endmodule

// File: rtl/eews_ctrl.sv
module eews_ctrl
  import eews_pkg::*;
#(
  parameter int WRITE_CYCLES = 400,
  parameter int CLEAR_CYCLES = 2560,
  parameter int MAIN_DEPTH   = 2048
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startEv,
  input  logic       endEv,
  input  logic       sOeN,
  input  logic       sHvOe,
  input  logic       sSupplyOk,
  output seqStrobe_t strb,
  output logic       busy
);

  localparam int MAX_CYC = (WRITE_CYCLES > CLEAR_CYCLES) ? WRITE_CYCLES : CLEAR_CYCLES;
  localparam int TMR_W   = $clog2(MAX_CYC + 1);
  localparam logic [TMR_W-1:0] ERASE_LAST = TMR_W'(WRITE_CYCLES / 2 - 1);
  localparam logic [TMR_W-1:0] WRITE_LAST = TMR_W'(WRITE_CYCLES - 1);
  localparam logic [TMR_W-1:0] CLEAR_LAST = TMR_W'(CLEAR_CYCLES - 1);
  localparam logic [TMR_W-1:0] SWEEP_END  = TMR_W'(MAIN_DEPTH);

  seqState_t        state;
  logic [TMR_W-1:0] timer;
  logic             armed;
  logic             idle;
  logic             commitByte;
  logic             commitClr;

  assign idle       = (state == ST_IDLE);
  assign commitByte = endEv && armed && idle && !sHvOe && sOeN && sSupplyOk;
  assign commitClr  = endEv && armed && idle && sHvOe && sSupplyOk;
  assign busy       = !idle;

  always_comb begin
    strb             = '0;
    strb.latchAddr   = startEv && idle;
    strb.latchData   = commitByte;
    strb.eraseByte   = commitByte;
    strb.sweepStart  = commitClr;
    strb.programByte = (state == ST_ERASE) && (timer == ERASE_LAST);
    strb.sweepStep   = (state == ST_CLEAR) && (timer < SWEEP_END);
    strb.byteBusy    = (state == ST_ERASE) || (state == ST_PROG);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (startEv && idle) begin
      armed <= 1'b1;
    end else if (endEv) begin
      armed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      timer <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          timer <= '0;
          if (commitByte)     state <= ST_ERASE;
          else if (commitClr) state <= ST_CLEAR;
        end
        ST_ERASE: begin
          timer <= timer + 1'b1;
          if (timer == ERASE_LAST) state <= ST_PROG;
        end
        ST_PROG: begin
          if (timer == WRITE_LAST) begin
            state <= ST_IDLE;
            timer <= '0;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        ST_CLEAR: begin
          if (timer == CLEAR_LAST) begin
            state <= ST_IDLE;
            timer <= '0;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/eews_datapath.sv
module eews_datapath
  import eews_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic              sCeN,
  input  logic              sWeN,
  input  logic              sOeN,
  input  logic              sHvOe,
  input  logic              sHvA9,
  input  logic [ADDR_W-1:0] sAddr,
  input  logic [7:0]        sData,
  output logic [ADDR_W-1:0] latchAddrQ,
  output logic [7:0]        latchDataQ,
  output logic [7:0]        dataOut,
  output logic              dataOe
);

  localparam int MAIN_DEPTH = 2 ** ADDR_W;

  logic [7:0]        mainMem [MAIN_DEPTH];
  logic [7:0]        idRow   [IDROW_BYTES];
  logic              latchIdQ;
  logic [ADDR_W-1:0] sweepIdx;
  logic              addrInIdWin;
  logic              rdEn;
  logic              rdIsId;
  logic              pollHit;
  logic [7:0]        rawVal;
  logic [7:0]        rdVal;

  assign addrInIdWin = &sAddr[ADDR_W-1:IDROW_AW];

  // Capture registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchAddrQ <= '0;
      latchIdQ   <= 1'b0;
      latchDataQ <= '0;
      sweepIdx   <= '0;
    end else begin
      if (strb.latchAddr) begin
        latchAddrQ <= sAddr;
        latchIdQ   <= sHvA9 && addrInIdWin;
      end
      if (strb.latchData) latchDataQ <= sData;
      if (strb.sweepStart)     sweepIdx <= '0;
      else if (strb.sweepStep) sweepIdx <= sweepIdx + 1'b1;
    end
  end

  // Main array: sweep erase, per-byte erase, then program
  always_ff @(posedge clk) begin
    if (strb.sweepStep)
      mainMem[sweepIdx] <= ERASED_BYTE;
    else if (strb.eraseByte && !latchIdQ)
      mainMem[latchAddrQ] <= ERASED_BYTE;
    else if (strb.programByte && !latchIdQ)
      mainMem[latchAddrQ] <= latchDataQ;
  end

  // Identification row: byte writes only, never swept
  always_ff @(posedge clk) begin
    if (strb.eraseByte && latchIdQ)
      idRow[latchAddrQ[IDROW_AW-1:0]] <= ERASED_BYTE;
    else if (strb.programByte && latchIdQ)
      idRow[latchAddrQ[IDROW_AW-1:0]] <= latchDataQ;
  end

  // Read path
  assign rdEn    = !sCeN && !sOeN && sWeN && !sHvOe;
  assign rdIsId  = sHvA9 && addrInIdWin;
  assign rawVal  = rdIsId ? idRow[sAddr[IDROW_AW-1:0]] : mainMem[sAddr];
  assign pollHit = strb.byteBusy && (sAddr == latchAddrQ) && (rdIsId == latchIdQ);
  assign rdVal   = pollHit ? {~latchDataQ[7], rawVal[6:0]} : rawVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= '0;
      dataOe  <= 1'b0;
    end else begin
      dataOe  <= rdEn;
      dataOut <= rdEn ? rdVal : 8'h00;
    end
  end

endmodule

// File: rtl/eeprom_write_seq.sv
module eeprom_write_seq
  import eews_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int WRITE_CYCLES = 400,
  parameter int CLEAR_CYCLES = 2560,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              hvOe,
  input  logic              hvA9,
  input  logic              supplyOk,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              dataOe,
  output wire               rdyBusyN
);

  localparam int MAIN_DEPTH = 2 ** ADDR_W;

  logic              sCeN, sWeN, sOeN, sHvOe, sHvA9, sSupplyOk;
  logic [ADDR_W-1:0] sAddr;
  logic [7:0]        sData;
  logic              startEv, endEv;
  logic              busy;
  seqStrobe_t        strb;
  logic [ADDR_W-1:0] latchAddrQ;
  logic [7:0]        latchDataQ;

  eews_pin_sync #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .hvOe(hvOe),
    .hvA9(hvA9), .supplyOk(supplyOk), .addr(addr), .dataIn(dataIn),
    .sCeN(sCeN), .sWeN(sWeN), .sOeN(sOeN), .sHvOe(sHvOe), .sHvA9(sHvA9),
    .sSupplyOk(sSupplyOk), .sAddr(sAddr), .sData(sData),
    .startEv(startEv), .endEv(endEv)
  );

  eews_ctrl #(
    .WRITE_CYCLES(WRITE_CYCLES), .CLEAR_CYCLES(CLEAR_CYCLES), .MAIN_DEPTH(MAIN_DEPTH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startEv(startEv), .endEv(endEv), .sOeN(sOeN),
    .sHvOe(sHvOe), .sSupplyOk(sSupplyOk), .strb(strb), .busy(busy)
  );

  eews_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sCeN(sCeN), .sWeN(sWeN), .sOeN(sOeN),
    .sHvOe(sHvOe), .sHvA9(sHvA9), .sAddr(sAddr), .sData(sData),
    .latchAddrQ(latchAddrQ), .latchDataQ(latchDataQ),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  // Open-drain: pull low while busy, float when ready
  assign rdyBusyN = busy ? 1'b0 : 1'bz;

endmodule

// File: rtl/eews_checker.sv
module eews_checker #(
  parameter int ADDR_W   = 11,
  parameter int MAX_BUSY = 2560
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              dataOe,
  input logic              sCeN,
  input logic              sOeN,
  input logic              sWeN,
  input logic              sHvOe,
  input logic              sSupplyOk,
  input logic [ADDR_W-1:0] latchAddrQ,
  input logic [7:0]        latchDataQ
);

  localparam int CNT_W = $clog2(MAX_BUSY + 2);
  logic [CNT_W-1:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      busyCnt <= '0;
    else if (!busy) busyCnt <= '0;
    else            busyCnt <= busyCnt + 1'b1;
  end

  // R3: a busy period never outlasts the longest timed sequence
  p_busy_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    busyCnt <= CNT_W'(MAX_BUSY));

  // R3: once busy starts it lasts more than one cycle
  p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> busy);

  // R7: a sequence only begins with the supply reported good
  p_start_supply_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(sSupplyOk));

  // R7: a byte write only begins with output enable high
  p_start_oe_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy) && !$past(sHvOe)) |-> $past(sOeN));

  // R6: captured address and data hold still for a whole sequence
  p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(latchAddrQ) && $stable(latchDataQ)));

  // R8: output drive follows a qualified read one cycle earlier
  p_drive_qual_r8: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> $past(!sCeN && !sOeN && sWeN));

endmodule

bind eeprom_write_seq eews_checker #(
  .ADDR_W(ADDR_W),
  .MAX_BUSY((WRITE_CYCLES > CLEAR_CYCLES) ? WRITE_CYCLES : CLEAR_CYCLES)
) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .dataOe(dataOe), .sCeN(sCeN),
  .sOeN(sOeN), .sWeN(sWeN), .sHvOe(sHvOe), .sSupplyOk(sSupplyOk),
  .latchAddrQ(latchAddrQ), .latchDataQ(latchDataQ)
);

// File: tb/test_eeprom_write_seq.sv
`timescale 1ns/1ps
module test_eeprom_write_seq;

  localparam int AW  = 11;
  localparam int WRC = 200;
  localparam int CLC = 2200;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic          hvOe = 1'b0, hvA9 = 1'b0, supplyOk = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    dataIn = '0;
  logic [7:0]    dataOut;
  logic          dataOe;
  wire           rdyBusyN;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  pullup (rdyBusyN);

  always #2 clk = ~clk;

  eeprom_write_seq #(.ADDR_W(AW), .WRITE_CYCLES(WRC), .CLEAR_CYCLES(CLC)) i_eeprom_write_seq (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .hvOe(hvOe),
    .hvA9(hvA9), .supplyOk(supplyOk), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe), .rdyBusyN(rdyBusyN)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitReady();
    while (rdyBusyN !== 1'b1) @(negedge clk);
    gap(2);
  endtask

  task automatic doRead(input logic [AW-1:0] a, input bit idRow,
                        output logic [7:0] val, output logic oe);
    addr = a; hvA9 = idRow; weN = 1'b1;
    ceN = 1'b0; oeN = 1'b0;
    gap(5);
    val = dataOut; oe = dataOe;
    oeN = 1'b1; ceN = 1'b1; hvA9 = 1'b0;
    gap(3);
  endtask

  // Full write cycle; data is corrupted after the capturing rise (R2)
  task automatic doWrite(input logic [AW-1:0] a, input logic [7:0] d,
                         input bit ceLast, input bit idRow, input bit oeLow);
    addr = a; hvA9 = idRow; oeN = !oeLow;
    if (ceLast) begin weN = 1'b0; gap(3); ceN = 1'b0; end
    else        begin ceN = 1'b0; gap(3); weN = 1'b0; end
    gap(3);
    dataIn = d;
    gap(3);
    if (ceLast) ceN = 1'b1; else weN = 1'b1;
    gap(3);
    dataIn = ~d;
    if (ceLast) weN = 1'b1; else ceN = 1'b1;
    gap(3);
    hvA9 = 1'b0; oeN = 1'b1;
  endtask

  task automatic tReset();
    check(rdyBusyN === 1'b1, "R3 reset ready", int'(rdyBusyN), 1);
    check(dataOe === 1'b0, "R8 reset no drive", int'(dataOe), 0);
  endtask

  task automatic tTimedWrite();
    logic [7:0] v; logic oe; int k; int n;
    addr = 11'h100; ceN = 1'b0; gap(3); weN = 1'b0; gap(3);
    dataIn = 8'h0F; gap(3);
    weN = 1'b1;
    k = 0;
    while (rdyBusyN !== 1'b0 && k < 20) begin @(negedge clk); k++; end
    check(k >= 1 && k <= 4, "R3 busy delay", k, 3);
    n = 0;
    while (rdyBusyN === 1'b0) begin n++; @(negedge clk); end
    check(n == WRC, "R3 busy length", n, WRC);
    ceN = 1'b1; gap(3);
    doRead(11'h100, 1'b0, v, oe);
    check(v == 8'h0F, "R4 first value", v, 8'h0F);
    doWrite(11'h100, 8'hF0, 1'b0, 1'b0, 1'b0);
    doRead(11'h100, 1'b0, v, oe);
    check(oe && v[7] == 1'b0, "R5 poll bit7 inverted", v[7], 0);
    check(rdyBusyN === 1'b0, "R3 busy during poll", int'(rdyBusyN), 0);
    waitReady();
    doRead(11'h100, 1'b0, v, oe);
    check(v == 8'hF0, "R4 erase then program", v, 8'hF0);
    check(v[7] == 1'b1, "R5 true bit7 after done", v[7], 1);
  endtask

  task automatic tCapture();
    logic [7:0] v; logic oe;
    doWrite(11'h066, 8'h77, 1'b0, 1'b0, 1'b0); waitReady();
    addr = 11'h055; weN = 1'b0; gap(3); ceN = 1'b0; gap(3);
    addr = 11'h066; dataIn = 8'h3C; gap(3);
    ceN = 1'b1; gap(3);
    dataIn = 8'hC3; weN = 1'b1; gap(3);
    waitReady();
    doRead(11'h055, 1'b0, v, oe);
    check(v == 8'h3C, "R1 R2 captured addr/data", v, 8'h3C);
    doRead(11'h066, 1'b0, v, oe);
    check(v == 8'h77, "R1 late address ignored", v, 8'h77);
  endtask

  task automatic tInhibit();
    logic [7:0] v; logic oe; bit sawBusy;
    doWrite(11'h066, 8'h12, 1'b0, 1'b0, 1'b1);
    sawBusy = 1'b0;
    repeat (6) begin @(negedge clk); if (rdyBusyN === 1'b0) sawBusy = 1'b1; end
    check(!sawBusy, "R7 oeN low no busy", sawBusy, 0);
    supplyOk = 1'b0;
    doWrite(11'h066, 8'h34, 1'b1, 1'b0, 1'b0);
    repeat (6) begin @(negedge clk); if (rdyBusyN === 1'b0) sawBusy = 1'b1; end
    supplyOk = 1'b1;
    check(!sawBusy, "R7 supply low no busy", sawBusy, 0);
    doRead(11'h066, 1'b0, v, oe);
    check(v == 8'h77, "R7 memory unchanged", v, 8'h77);
  endtask

  task automatic tBusyIgnore();
    logic [7:0] v; logic oe;
    doWrite(11'h020, 8'h99, 1'b0, 1'b0, 1'b0); waitReady();
    doWrite(11'h010, 8'h11, 1'b0, 1'b0, 1'b0);
    doWrite(11'h020, 8'h22, 1'b1, 1'b0, 1'b0);
    waitReady();
    doRead(11'h020, 1'b0, v, oe);
    check(v == 8'h99, "R6 busy write ignored", v, 8'h99);
    doRead(11'h010, 1'b0, v, oe);
    check(v == 8'h11, "R6 first write intact", v, 8'h11);
  endtask

  task automatic tStandby();
    logic [7:0] v; logic oe;
    doRead(11'h010, 1'b0, v, oe);
    check(oe == 1'b1, "R8 read drives", oe, 1);
    addr = 11'h010; ceN = 1'b1; oeN = 1'b0; gap(5);
    check(dataOe == 1'b0, "R8 standby released", dataOe, 0);
    oeN = 1'b1; gap(3);
    ceN = 1'b0; weN = 1'b0; oeN = 1'b0; gap(5);
    check(dataOe == 1'b0, "R8 weN low no drive", dataOe, 0);
    weN = 1'b1; gap(3);
    oeN = 1'b1; ceN = 1'b1; gap(5);
    check(rdyBusyN === 1'b1, "R7 no write from oe-low cycle", int'(rdyBusyN), 1);
  endtask

  task automatic tIdRow();
    logic [7:0] v; logic oe;
    doWrite(11'h7E3, 8'h11, 1'b0, 1'b0, 1'b0); waitReady();
    doWrite(11'h7E3, 8'h5A, 1'b1, 1'b1, 1'b0); waitReady();
    doRead(11'h7E3, 1'b1, v, oe);
    check(v == 8'h5A, "R10 id row readback", v, 8'h5A);
    doRead(11'h7E3, 1'b0, v, oe);
    check(v == 8'h11, "R10 main array untouched", v, 8'h11);
  endtask

  task automatic tChipClear();
    logic [7:0] v; logic oe; int n;
    hvOe = 1'b1; ceN = 1'b0; gap(3); weN = 1'b0; gap(3);
    weN = 1'b1;
    while (rdyBusyN !== 1'b0) @(negedge clk);
    n = 0;
    while (rdyBusyN === 1'b0) begin n++; @(negedge clk); end
    check(n == CLC, "R9 clear length", n, CLC);
    ceN = 1'b1; hvOe = 1'b0; gap(3);
    doRead(11'h100, 1'b0, v, oe);
    check(v == 8'hFF, "R9 main cleared 0x100", v, 8'hFF);
    doRead(11'h7E3, 1'b0, v, oe);
    check(v == 8'hFF, "R9 main cleared 0x7E3", v, 8'hFF);
    doRead(11'h7E3, 1'b1, v, oe);
    check(v == 8'h5A, "R9 R10 id row kept", v, 8'h5A);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog R3 actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    gap(3);
    tReset();
    rstN = 1'b1;
    gap(3);
    tReset();
    tTimedWrite();
    tCapture();
    tInhibit();
    tBusyIgnore();
    tStandby();
    tIdRow();
    tChipClear();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule